// File: doc/BRIEF.md
# Predicated Saturating Bidirectional Vector Shifter

This block is a vector datapath that splits a wide operand into independent signed 64-bit lanes. In each lane, a signed count moves a data value. A count of zero or more moves it toward the most significant end. A negative count moves it the other way, and the distance is the magnitude of the count. A result that does not fit in 64 signed bits is clamped to the nearest signed extreme.

The operand roles are reversed. The incoming destination vector supplies the per-lane counts, and the source vector supplies the values to be moved. A per-lane predicate chooses what each lane produces. An active lane takes the new result. An inactive lane passes the incoming destination lane through unchanged.

Results and per-lane clamp flags are registered. They appear one cycle after the input strobe, together with an output valid. The vector width is a parameter from 128 to 2048 bits.

Top module: `vshl_sat_vec`

## Requirements
- R1: The vector is processed as LANES = VEC_W/64 independent lanes. Lane i occupies bits [64*i+63:64*i] of every vector port, and predicate bit i governs lane i. Any VEC_W that is a multiple of 64 from 128 to 2048 is accepted.
- R2: In lane i, the destination lane is a two's-complement count and the source lane is the value. When the count is zero or positive, the active lane result is the value times 2^count whenever that fits in 64 signed bits.
- R3: When the count is negative, the active lane result is an arithmetic right shift of the value by the count's magnitude, with no rounding and no clamping. A magnitude of 64 or more gives 0 for a non-negative value and -1 (all ones) for a negative value. This includes the count -2^63.
- R4: When a left shift does not fit, the result is 0x7FFFFFFFFFFFFFFF for a positive value and 0x8000000000000000 for a negative value.
- R5: A zero value gives 0 and never clamps, for any count. A nonzero value with a count of 64 or more always clamps.
- R6: A lane whose predicate bit is 0 outputs the incoming destination lane unchanged.
- R7: Flag bit i (sat_flags) is 1 only when lane i was active and its result was clamped.
- R8: out_valid is 1 exactly in the cycle after a cycle with in_valid = 1, and out_vec and sat_flags carry that input's results in that same cycle.
- R9: A synchronous active-high reset clears out_vec, sat_flags and out_valid to 0. While in_valid is 0, out_vec and sat_flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| dst_vec | input | VEC_W | Per-lane counts and merge values |
| src_vec | input | VEC_W | Per-lane values to shift |
| pred | input | VEC_W/64 | Per-lane active mask |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_vec | output | VEC_W | Registered result vector |
| sat_flags | output | VEC_W/64 | Registered per-lane clamp flags |

## Verification
The bench builds the block with VEC_W = 256, which gives four lanes. With four lanes, a single vector can mix active and inactive lanes, clamped and unclamped lanes, and left and right shifts. That makes it possible to see lane isolation and merge behaviour in each transfer. Directed vectors cover the count boundaries at 63, 64, -63, -64 and -2^63, and the values 0, -1 and both signed extremes. Random vectors, drawn with a bias toward those boundaries, fill in the space between them.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
  localparam int LANE_W = 64;
  localparam int AMT_W  = 6;

  typedef logic signed [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic             left;
    logic             huge;
    logic [AMT_W-1:0] amt;
  } shdec_t;

  localparam lane_t LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam lane_t LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
endpackage

// File: rtl/vshl_cnt_dec.sv
module vshl_cnt_dec
  import vshl_pkg::*;
(
  input  lane_t  cnt,
  output shdec_t dec
);
  logic upper_ones;
  logic upper_zero;

  always_comb begin
    upper_ones = &cnt[LANE_W-2:AMT_W];
    upper_zero = ~|cnt[LANE_W-2:AMT_W];
    dec.left   = ~cnt[LANE_W-1];
    if (!cnt[LANE_W-1]) begin
      dec.huge = ~upper_zero;
      dec.amt  = cnt[AMT_W-1:0];
    end else begin
      // magnitude 1..63 only when upper bits are all ones and low part non-zero
      dec.huge = ~upper_ones | (cnt[AMT_W-1:0] == '0);
      dec.amt  = (~cnt[AMT_W-1:0]) + AMT_W'(1);
    end
  end
endmodule

// File: rtl/vshl_lane_shift.sv
module vshl_lane_shift
  import vshl_pkg::*;
(
  input  lane_t  val,
  input  shdec_t dec,
  output lane_t  res,
  output logic   sat
);
  logic [2*LANE_W-1:0] wide;
  logic                ovf;
  lane_t               clamp;
  logic                is_zero;

  always_comb begin
    is_zero = (val == '0);
    clamp   = val[LANE_W-1] ? LANE_MIN : LANE_MAX;
    wide    = {{LANE_W{val[LANE_W-1]}}, val} << dec.amt;
    ovf     = (wide[2*LANE_W-1:LANE_W-1] != {(LANE_W+1){val[LANE_W-1]}});
    res     = '0;
    sat     = 1'b0;
    if (dec.left) begin
      if (dec.huge) begin
        sat = ~is_zero;
        res = is_zero ? lane_t'(0) : clamp;
      end else begin
        sat = ovf;
        res = ovf ? clamp : lane_t'(wide[LANE_W-1:0]);
      end
    end else begin
      res = dec.huge ? lane_t'({LANE_W{val[LANE_W-1]}}) : (val >>> dec.amt);
    end
  end
endmodule

// File: rtl/vshl_lane.sv
module vshl_lane
  import vshl_pkg::*;
(
  input  lane_t dst,
  input  lane_t src,
  input  logic  act,
  output lane_t nxt,
  output logic  sat
);
  shdec_t dec;
  lane_t  shres;
  logic   shsat;

  vshl_cnt_dec u_dec (
    .cnt (dst),
    .dec (dec)
  );

  vshl_lane_shift u_shift (
    .val (src),
    .dec (dec),
    .res (shres),
    .sat (shsat)
  );

  assign nxt = act ? shres : dst;
  assign sat = act & shsat;
endmodule

// File: rtl/vshl_sat_vec.sv
module vshl_sat_vec
  import vshl_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [VEC_W-1:0]          dst_vec,
  input  logic [VEC_W-1:0]          src_vec,
  input  logic [VEC_W/LANE_W-1:0]   pred,
  output logic                      out_valid,
  output logic [VEC_W-1:0]          out_vec,
  output logic [VEC_W/LANE_W-1:0]   sat_flags
);
  localparam int LANES = VEC_W / LANE_W;

  logic [VEC_W-1:0] nxt_vec;
  logic [LANES-1:0] nxt_sat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_t l_nxt;
    vshl_lane u_lane (
      .dst (lane_t'(dst_vec[g*LANE_W +: LANE_W])),
      .src (lane_t'(src_vec[g*LANE_W +: LANE_W])),
      .act (pred[g]),
      .nxt (l_nxt),
      .sat (nxt_sat[g])
    );
    assign nxt_vec[g*LANE_W +: LANE_W] = l_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec   <= nxt_vec;
        sat_flags <= nxt_sat;
      end
    end
  end
endmodule

// File: rtl/vshl_sat_vec_chk.sv
module vshl_sat_vec_chk
  import vshl_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [VEC_W-1:0]        dst_vec,
  input logic [VEC_W-1:0]        src_vec,
  input logic [VEC_W/LANE_W-1:0] pred,
  input logic                    out_valid,
  input logic [VEC_W-1:0]        out_vec,
  input logic [VEC_W/LANE_W-1:0] sat_flags
);
  localparam int LANES = VEC_W / LANE_W;

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_cause_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_vec) && $stable(sat_flags)));

  p_flag_active_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((sat_flags & ~$past(pred)) == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lchk
    p_merge_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(pred[g])) |->
        (out_vec[g*LANE_W +: LANE_W] == $past(dst_vec[g*LANE_W +: LANE_W])));

    p_clamp_value_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && sat_flags[g]) |->
        ((out_vec[g*LANE_W +: LANE_W] == LANE_MAX) ||
         (out_vec[g*LANE_W +: LANE_W] == LANE_MIN)));

    p_zero_val_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(pred[g]) && ($past(src_vec[g*LANE_W +: LANE_W]) == '0)) |->
        ((out_vec[g*LANE_W +: LANE_W] == '0) && !sat_flags[g]));

    p_right_nosat_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(dst_vec[g*LANE_W + LANE_W - 1])) |-> !sat_flags[g]);
  end
endmodule

bind vshl_sat_vec vshl_sat_vec_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_vshl_sat_vec.sv
`timescale 1ns/1ps
module tb_vshl_sat_vec;
  localparam int VEC_W = 256;
  localparam int LANES = VEC_W / 64;
  localparam longint MAXV = 64'sh7FFFFFFFFFFFFFFF;
  localparam longint MINV = 64'sh8000000000000000;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [VEC_W-1:0] dst_vec, src_vec;
  logic [LANES-1:0] pred;
  logic             out_valid;
  logic [VEC_W-1:0] out_vec;
  logic [LANES-1:0] sat_flags;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  vshl_sat_vec #(.VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .dst_vec(dst_vec), .src_vec(src_vec), .pred(pred),
    .out_valid(out_valid), .out_vec(out_vec), .sat_flags(sat_flags)
  );

  function automatic void ref_lane(input longint c, input longint v,
                                   output longint r, output bit s, output string tag);
    longint t;
    s = 1'b0;
    if (c >= 0) begin
      if (v == 0) begin
        r = 0; tag = "R5";
      end else if (c >= 64) begin
        s = 1'b1; r = (v < 0) ? MINV : MAXV; tag = "R5";
      end else begin
        t = v <<< c;
        if ((t >>> c) != v) begin
          s = 1'b1; r = (v < 0) ? MINV : MAXV; tag = "R4";
        end else begin
          r = t; tag = "R2";
        end
      end
    end else if (c < -63) begin
      r = (v < 0) ? -64'sd1 : 64'sd0; tag = "R3";
    end else begin
      r = v >>> (-c); tag = "R3";
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [VEC_W-1:0] d, input logic [VEC_W-1:0] s,
                         input logic [LANES-1:0] p);
    longint er, ar;
    bit     es;
    string  tag;
    @(negedge clk);
    dst_vec = d; src_vec = s; pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R8", "out_valid", longint'(out_valid), 1);
    for (int i = 0; i < LANES; i++) begin
      if (p[i]) ref_lane(d[i*64 +: 64], s[i*64 +: 64], er, es, tag);
      else begin er = d[i*64 +: 64]; es = 1'b0; tag = "R6"; end
      ar = out_vec[i*64 +: 64];
      check(ar == er, tag, $sformatf("lane%0d value", i), ar, er);
      check(sat_flags[i] == es, "R7", $sformatf("lane%0d flag", i),
            longint'(sat_flags[i]), longint'(es));
    end
  endtask

  task automatic hold_check();
    logic [VEC_W-1:0] sv;
    logic [LANES-1:0] sf;
    sv = out_vec; sf = sat_flags;
    @(negedge clk);
    dst_vec = ~dst_vec; src_vec = {VEC_W/32{$urandom}}; pred = ~pred; in_valid = 1'b0;
    @(negedge clk);
    check(out_vec == sv && sat_flags == sf, "R9", "hold", longint'(out_vec[63:0]), longint'(sv[63:0]));
    check(out_valid == 1'b0, "R8", "idle out_valid", longint'(out_valid), 0);
  endtask

  function automatic longint rnd_cnt();
    case ($urandom % 6)
      0: return longint'($urandom % 71);
      1: return -longint'($urandom % 71);
      2: return {$urandom, $urandom};
      3: return MINV;
      4: return 64 + longint'($urandom % 1000);
      default: return -64 - longint'($urandom % 1000);
    endcase
  endfunction

  function automatic longint rnd_val();
    case ($urandom % 7)
      0: return 0;
      1: return MAXV;
      2: return MINV;
      3: return -1;
      4: return longint'($urandom % 16) - 8;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] d, s;
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; dst_vec = '0; src_vec = '0; pred = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(out_vec == '0 && sat_flags == '0, "R9", "reset out", longint'(out_vec[63:0]), 0);
    check(out_valid == 1'b0, "R9", "reset valid", longint'(out_valid), 0);

    // R4 / R2: left clamp and exact edges
    d = {64'sd62, 64'sd63, 64'sd1, 64'sd1};
    s = {64'sd1, -64'sd1, MINV, MAXV};
    run_vec(d, s, 4'b1111);
    // R6: same input, alternate lanes inactive
    run_vec(d, s, 4'b0101);
    // R3: right-shift boundaries including -2^63
    d = {-64'sd63, -64'sd1, MINV, -64'sd64};
    s = {MINV, -64'sd3, 64'sd100, -64'sd5};
    run_vec(d, s, 4'b1111);
    // R5: zero value with huge counts, nonzero with count 64
    d = {64'sd64, 64'sd64, MAXV, 64'sd200};
    s = {-64'sd1, 64'sd1, 64'sd0, 64'sd0};
    run_vec(d, s, 4'b1111);
    // R1: lanes independent; count 63 on value 1 clamps in one lane only
    d = {64'sd0, 64'sd63, -64'sd2, 64'sd0};
    s = {64'sd7, 64'sd1, 64'sd8, -64'sd9};
    run_vec(d, s, 4'b1111);
    hold_check();

    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < LANES; i++) begin
        d[i*64 +: 64] = rnd_cnt();
        s[i*64 +: 64] = rnd_val();
      end
      run_vec(d, s, LANES'($urandom));
      if (n % 50 == 0) hold_check();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule